// File: doc/BRIEF.md
# Stepwise Multiply and Divide Unit

This unit provides an unsigned 8×8 multiplier and an unsigned 16÷8 divider behind a small byte-wide register bus. Software writes the operands into byte registers. A write to the second multiplicand starts a multiplication. A write to the divisor starts a division. Each arithmetic operation then advances by exactly one step per clock: 8 steps for a multiplication and 16 steps for a division.

The unit has two 16-bit result registers, each read as a low byte and a high byte. The first holds the quotient. The second holds either the product or the remainder. Both registers are updated on every step, so a read taken before the operation ends returns a partial value. The `busy` output is high while steps remain. A start write that arrives while an operation is still running still clears or loads the product/remainder register. It does not capture its operand and does not restart anything.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, every result byte (read addresses 0 to 3) reads 0x00 and `busy` is low.
- R2: Write addresses are: 0 = multiplicand A, 1 = multiplier B (starts a multiply), 2 = dividend low byte, 3 = dividend high byte, 4 = divisor (starts a divide). Read addresses are: 0 = quotient low, 1 = quotient high, 2 = product/remainder low, 3 = product/remainder high. Read addresses 4 to 7 return 0x00.
- R3: A write to address 1 while idle does three things: it clears the product, loads the quotient register with {B, A}, and starts an 8-step multiply. Once the multiply finishes, the product register holds A×B and the quotient register holds B.
- R4: During a multiply, k steps after the start edge, the product register holds B × (A mod 2^k).
- R5: A write to address 4 while idle loads the product/remainder register with the dividend and starts a 16-step restoring divide. Once the divide finishes, the quotient and remainder registers hold the unsigned quotient and remainder of dividend ÷ divisor.
- R6: A divisor of 0 yields a quotient of 0xFFFF and a remainder equal to the dividend.
- R7: A write to address 1 while busy clears the product register at that edge. It does not load the quotient register, does not capture the new multiplier and does not restart. The running operation ends on its original schedule.
- R8: A write to address 4 while busy loads the product/remainder register with the dividend at that edge. It does not start a divide. The running operation ends on its original schedule.
- R9: While idle, writes to addresses 0, 2 and 3 leave both result registers unchanged.
- R10: `busy` rises at the start edge and stays high for exactly 8 clock cycles for a multiply, or 16 for a divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for both writes and reads |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, combinational from `addr` |
| busy | output | 1 | High while arithmetic steps remain |

## Verification
The hardest case to reach is a start write that lands in the middle of a running operation. This is the only case in which the clear or copy into the product/remainder register overrides an arithmetic step at the same edge, while the counter and the quotient keep stepping. The directed tasks launch a multiply, count a fixed number of falling edges, and then issue either a multiplier write or a divisor write. They read the product register right after that edge and check that `busy` still falls on the original eighth cycle. They also check that the final quotient still equals the first multiplier, which shows the second operand was never captured.

// File: rtl/muldiv_unit.sv
module muldiv_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam int MUL_STEPS = 8;
  localparam int DIV_STEPS = 16;

  logic [7:0]  opa_q;
  logic [15:0] dvd_q;
  logic [15:0] quo_q;
  logic [15:0] prd_q;
  logic [23:0] sh_q;
  logic [4:0]  cnt_q;
  logic        is_div_q;

  logic        mul_go, div_go;
  logic [23:0] sh_dn;
  logic        fits;
  logic [23:0] diff;

  assign mul_go = wr_en && addr == 3'd1;
  assign div_go = wr_en && addr == 3'd4;
  assign busy   = cnt_q != 5'd0;
  assign sh_dn  = sh_q >> 1;
  assign fits   = {8'd0, prd_q} >= sh_dn;
  assign diff   = {8'd0, prd_q} - sh_dn;

  always_comb begin
    case (addr)
      3'd0:    rd_data = quo_q[7:0];
      3'd1:    rd_data = quo_q[15:8];
      3'd2:    rd_data = prd_q[7:0];
      3'd3:    rd_data = prd_q[15:8];
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q    <= '0;
      dvd_q    <= '0;
      quo_q    <= '0;
      prd_q    <= '0;
      sh_q     <= '0;
      cnt_q    <= '0;
      is_div_q <= 1'b0;
    end else begin
      if (wr_en && addr == 3'd0) opa_q        <= wr_data;
      if (wr_en && addr == 3'd2) dvd_q[7:0]   <= wr_data;
      if (wr_en && addr == 3'd3) dvd_q[15:8]  <= wr_data;

      if (busy) begin
        cnt_q <= cnt_q - 5'd1;
        if (is_div_q) begin
          sh_q  <= sh_dn;
          quo_q <= {quo_q[14:0], fits};
          if (fits) prd_q <= diff[15:0];
        end else begin
          if (quo_q[0]) prd_q <= prd_q + sh_q[15:0];
          quo_q <= quo_q >> 1;
          sh_q  <= sh_q << 1;
        end
      end

      if (mul_go) begin
        prd_q <= '0;
        if (!busy) begin
          quo_q    <= {wr_data, opa_q};
          sh_q     <= {16'd0, wr_data};
          cnt_q    <= 5'(MUL_STEPS);
          is_div_q <= 1'b0;
        end
      end

      if (div_go) begin
        prd_q <= dvd_q;
        if (!busy) begin
          sh_q     <= {wr_data, 16'd0};
          cnt_q    <= 5'(DIV_STEPS);
          is_div_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic        busy,
  input logic [15:0] prd,
  input logic [15:0] quo,
  input logic [15:0] dvd
);
  logic [5:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 6'd1 : 6'd0;
  end

  assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 6'd8 || run_q == 6'd16));

  assert_mul_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !busy) |=> busy);

  assert_div_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && !busy) |=> busy);

  assert_mul_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> prd == 16'd0);

  assert_div_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> prd == $past(dvd));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(wr_en && (addr == 3'd1 || addr == 3'd4))) |=> ($stable(prd) && $stable(quo)));
endmodule

bind muldiv_unit muldiv_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy),
  .prd(prd_q), .quo(quo_q), .dvd(dvd_q)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    addr = a;     #1; v[7:0]  = rd_data;
    addr = a + 1; #1; v[15:8] = rd_data;
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] q, p;
    rd16(3'd0, q); rd16(3'd2, p);
    check("R1 quotient", q, 0);
    check("R1 product", p, 0);
    check("R1 busy", busy, 0);
  endtask

  task automatic t_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] q, p;
    wr(3'd0, a);
    wr(3'd1, b);
    rd16(3'd0, q); rd16(3'd2, p);
    check("R3 quotient load", q, {b, a});
    check("R3 product clear", p, 0);
    check("R10 busy after start", busy, 1);
    steps(7);
    check("R10 busy at step 7", busy, 1);
    steps(1);
    check("R10 busy at step 8", busy, 0);
    rd16(3'd0, q); rd16(3'd2, p);
    check("R3 product", p, a * b);
    check("R3 quotient holds B", q, b);
  endtask

  task automatic t_mul_partial;
    logic [15:0] p;
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h10);
    steps(3);
    rd16(3'd2, p);
    check("R4 partial product k=3", p, 16'h0070);
    steps(2);
    rd16(3'd2, p);
    check("R4 partial product k=5", p, 16'h01F0);
    steps(3);
  endtask

  task automatic t_div(input logic [15:0] n, input logic [7:0] d, input string req);
    logic [15:0] q, r;
    wr(3'd2, n[7:0]);
    wr(3'd3, n[15:8]);
    wr(3'd4, d);
    rd16(3'd2, r);
    check({req, " remainder load"}, r, n);
    steps(15);
    check("R10 busy at step 15", busy, 1);
    steps(1);
    check("R10 busy at step 16", busy, 0);
    rd16(3'd0, q); rd16(3'd2, r);
    if (d == 0) begin
      check({req, " quotient"}, q, 16'hFFFF);
      check({req, " remainder"}, r, n);
    end else begin
      check({req, " quotient"}, q, n / d);
      check({req, " remainder"}, r, n % d);
    end
  endtask

  task automatic t_mul_restart_ignored;
    logic [15:0] q, p;
    wr(3'd0, 8'h07);
    wr(3'd1, 8'h09);
    steps(2);
    wr(3'd1, 8'h55);
    rd16(3'd2, p);
    check("R7 product cleared", p, 0);
    steps(4);
    check("R7 still busy step 7", busy, 1);
    steps(1);
    check("R7 ends on schedule", busy, 0);
    rd16(3'd0, q); rd16(3'd2, p);
    check("R7 quotient not reloaded", q, 16'h0009);
    check("R7 final product", p, 0);
  endtask

  task automatic t_div_start_ignored;
    logic [15:0] q, p;
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h05);
    steps(1);
    wr(3'd4, 8'h10);
    rd16(3'd2, p);
    check("R8 dividend copied", p, 16'h1234);
    steps(5);
    check("R8 still busy step 7", busy, 1);
    steps(1);
    check("R8 no divide started", busy, 0);
    rd16(3'd0, q); rd16(3'd2, p);
    check("R8 quotient", q, 16'h0005);
    check("R8 product", p, 16'h1234);
  endtask

  task automatic t_idle_writes;
    logic [15:0] q0, p0, q1, p1;
    rd16(3'd0, q0); rd16(3'd2, p0);
    wr(3'd0, 8'hA5);
    wr(3'd2, 8'h5A);
    wr(3'd3, 8'hC3);
    rd16(3'd0, q1); rd16(3'd2, p1);
    check("R9 quotient unchanged", q1, q0);
    check("R9 product unchanged", p1, p0);
    addr = 3'd5; #1;
    check("R2 unmapped read", rd_data, 0);
    addr = 3'd7; #1;
    check("R2 unmapped read", rd_data, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul(8'h12, 8'h34);
    t_mul(8'hFF, 8'hFF);
    t_mul(8'hAB, 8'h00);
    t_mul_partial();
    t_div(16'h1234, 8'h56, "R5");
    t_div(16'hFFFF, 8'hFF, "R5");
    t_div(16'h0005, 8'h07, "R5");
    t_div(16'h03E8, 8'h00, "R6");
    t_mul_restart_ignored();
    t_div_start_ignored();
    t_div(16'h1234, 8'h10, "R5 after ignored start");
    t_idle_writes();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule